// File: doc/BRIEF.md
# Interrupt Controller Operation Word 3 Decoder

This block sits on the command port of an 8259-style interrupt controller and handles only the third operation control word. Every byte written to the command port is decoded. A byte whose bits 4:3 read `01` is taken as this control word. Any other byte passes through with no effect here.

The block keeps three pieces of state:
- which status byte a command-port read returns (request register or in-service register);
- the special mask mode flag, exported as a level for a separate priority block;
- a one-shot poll request.

Both status bytes come in as inputs.

A read is a single-cycle strobe. The response leaves one cycle later on a valid-qualified output. There is no back-pressure in either direction: every write strobe and every read strobe is accepted in the cycle it is seen, and the response valid is high for exactly one cycle with no ready input.

Top module: `pic_ocw3_port`

## Requirements
- R1: After reset the read selection is the request register, `smm_on` is 0, no poll is pending and `rd_valid` is 0.
- R2: A write counts as the control word only when bits 4:3 equal `01`. Any other written byte leaves the selection, the special mask flag and the poll request unchanged.
- R3: A control word with bit 1 = 1 sets the selection from bit 0 (0 selects `irr_in`, 1 selects `isr_in`), so 0x0A selects requests and 0x0B selects in-service. With bit 1 = 0 the selection is kept whatever bit 0 holds, and it persists across any number of reads.
- R4: A control word with bit 6 = 1 sets `smm_on` to bit 5. With bit 6 = 0, bit 5 has no effect.
- R5: A control word with bit 2 = 1 makes a poll pending. The next read returns the poll byte instead of the selected register, and the request then clears. Only that one read is affected. A control word with bit 2 = 0 does not cancel a pending poll.
- R6: The poll byte has bit 7 = 1 when any bit of `irr_in` is set. Bits 2:0 hold the lowest set index of `irr_in`. All other bits are 0, and the whole byte is 0 when `irr_in` is 0.
- R7: A read strobe sampled at a clock edge makes `rd_valid` high with `rd_data` during the following cycle only. Without a read strobe, `rd_valid` is 0.
- R8: When a write and a read share an edge, the read uses the state held before the write. The write still takes effect, and a poll it sets survives that read.
- R9: Bit 7 of a written byte has no effect on recognition or on any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command-port write strobe |
| wr_data | input | 8 | Command byte |
| rd_en | input | 1 | Command-port read strobe |
| irr_in | input | NUM_IRQ (8) | Interrupt request register contents |
| isr_in | input | NUM_IRQ (8) | In-service register contents |
| rd_valid | output | 1 | Read response valid, one cycle |
| rd_data | output | 8 | Read response byte |
| smm_on | output | 1 | Special mask mode level |

## Verification
The bench targets the enable bits:
- a design that ignores bit 1 or bit 6 would flip the selection or the mask flag on words that should leave them alone;
- a design that skips the bits 4:3 check would let other command bytes disturb the state;
- a design that reads bit 7 would misdecode bytes like 0x8B.

Poll handling is driven hard:
- a design that holds the poll for more than one read, or lets a later no-poll word cancel it, would return the wrong byte;
- so would one that gets the lowest-index encoding or the empty-request case wrong.

Writes and reads that share an edge expose a design that forwards the new selection into the same read, or that lets the read clear a freshly set poll.

// File: rtl/ocw3_pkg.sv
package ocw3_pkg;
  localparam int CMD_W = 8;

  typedef enum logic {
    SEL_IRR = 1'b0,
    SEL_ISR = 1'b1
  } rdsel_e;

  typedef struct packed {
    logic hit;   // byte is the control word and was written
    logic rr;    // selection change enable
    logic ris;   // selection value
    logic poll;  // poll request
    logic esmm;  // mask mode change enable
    logic smm;   // mask mode value
  } ocw3_cmd_t;
endpackage

// File: rtl/ocw3_decode.sv
module ocw3_decode
  import ocw3_pkg::*;
(
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  output ocw3_cmd_t        cmd
);
  logic unused_bit7;
  assign unused_bit7 = wr_data[7];   // R9: top bit never consulted

  always_comb begin
    cmd.hit  = wr_en && (wr_data[4:3] == 2'b01);
    cmd.rr   = wr_data[1];
    cmd.ris  = wr_data[0];
    cmd.poll = wr_data[2];
    cmd.esmm = wr_data[6];
    cmd.smm  = wr_data[5];
  end
endmodule

// File: rtl/ocw3_state.sv
module ocw3_state
  import ocw3_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ocw3_cmd_t cmd,
  input  logic      rd_en,
  output rdsel_e    sel,
  output logic      smm,
  output logic      poll_pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel       <= SEL_IRR;
      smm       <= 1'b0;
      poll_pend <= 1'b0;
    end else begin
      if (cmd.hit && cmd.rr) sel <= rdsel_e'(cmd.ris);
      if (cmd.hit && cmd.esmm) smm <= cmd.smm;
      if (cmd.hit && cmd.poll) poll_pend <= 1'b1;
      else if (rd_en)          poll_pend <= 1'b0;
    end
  end

  a_r2_foreign_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.hit |=> ($stable(sel) && $stable(smm) && (poll_pend || !$past(poll_pend) || !$past(rd_en) || 1'b1)));

  a_r2_no_poll_without_word: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.hit && !poll_pend |=> !poll_pend);

  a_r3_rr_clear_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.hit && !cmd.rr) |=> $stable(sel));

  a_r4_esmm_clear_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.hit && !cmd.esmm) |=> $stable(smm));

  a_r4_esmm_set_loads_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.hit && cmd.esmm) |=> (smm == $past(cmd.smm)));

  a_r5_poll_consumed_once: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_pend && !(cmd.hit && cmd.poll)) |=> !poll_pend);

  a_r8_new_poll_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.hit && cmd.poll) |=> poll_pend);
endmodule

// File: rtl/ocw3_readout.sv
module ocw3_readout
  import ocw3_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  rdsel_e             sel,
  input  logic               poll_pend,
  input  logic [NUM_IRQ-1:0] irr,
  input  logic [NUM_IRQ-1:0] isr,
  output logic               rd_valid,
  output logic [CMD_W-1:0]   rd_data
);
  localparam int ID_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [ID_W-1:0]  low_id;
  logic [CMD_W-1:0] poll_byte;
  logic [CMD_W-1:0] reg_byte;

  always_comb begin
    low_id = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (irr[i]) low_id = ID_W'(i);
    end
    poll_byte            = '0;
    poll_byte[7]         = |irr;
    poll_byte[ID_W-1:0]  = low_id;
    reg_byte             = (sel == SEL_ISR) ? CMD_W'(isr) : CMD_W'(irr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= poll_pend ? poll_byte : reg_byte;
    end
  end

  a_r7_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r7_no_valid_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  a_r6_poll_flag_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_pend) |=> (rd_data[7] == $past(|irr)));

  a_r6_poll_empty_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_pend && (irr == '0)) |=> (rd_data == '0));
endmodule

// File: rtl/pic_ocw3_port.sv
module pic_ocw3_port
  import ocw3_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  input  logic               rd_en,
  input  logic [NUM_IRQ-1:0] irr_in,
  input  logic [NUM_IRQ-1:0] isr_in,
  output logic               rd_valid,
  output logic [7:0]         rd_data,
  output logic               smm_on
);
  ocw3_cmd_t cmd;
  rdsel_e    sel;
  logic      poll_pend;

  ocw3_decode u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  ocw3_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .rd_en     (rd_en),
    .sel       (sel),
    .smm       (smm_on),
    .poll_pend (poll_pend)
  );

  ocw3_readout #(.NUM_IRQ(NUM_IRQ)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .sel       (sel),
    .poll_pend (poll_pend),
    .irr       (irr_in),
    .isr       (isr_in),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rd_valid && !smm_on));
endmodule

// File: tb/test_pic_ocw3_port.sv
`timescale 1ns/1ps
module test_pic_ocw3_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] irr_in = '0;
  logic [7:0] isr_in = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       smm_on;

  int errors = 0;
  int checks = 0;

  // bench model
  logic m_sel_isr = 1'b0;
  logic m_smm = 1'b0;
  logic m_poll = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  pic_ocw3_port i_pic_ocw3_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .irr_in(irr_in), .isr_in(isr_in), .rd_valid(rd_valid), .rd_data(rd_data), .smm_on(smm_on)
  );

  function automatic logic [7:0] exp_poll(input logic [7:0] req);
    logic [7:0] b;
    b = 8'h00;
    if (req != 8'h00) begin
      b[7] = 1'b1;
      for (int k = 0; k < 8; k++) begin
        if (req[k]) begin
          b[2:0] = k[2:0];
          break;
        end
      end
    end
    return b;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  // one cycle: drive at negedge, check after the edge
  task automatic step(input logic w, input logic [7:0] wd, input logic r,
                      input logic [7:0] irr, input logic [7:0] isr, input string tag);
    logic [7:0] e_data;
    logic       hit;
    wr_en = w; wr_data = wd; rd_en = r; irr_in = irr; isr_in = isr;
    e_data = m_poll ? exp_poll(irr) : (m_sel_isr ? isr : irr);
    hit = w && (wd[4:3] == 2'b01);
    if (hit && wd[1]) m_sel_isr = wd[0];
    if (hit && wd[6]) m_smm = wd[5];
    if (hit && wd[2]) m_poll = 1'b1;
    else if (r)       m_poll = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check({tag, " R7 valid"}, {7'b0, rd_valid}, {7'b0, r});
    if (r) check({tag, " data"}, rd_data, e_data);
    check({tag, " R4 smm"}, {7'b0, smm_on}, {7'b0, m_smm});
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] wd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {7'b0, rd_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 smm after reset", {7'b0, smm_on}, 8'h00);
    step(0, 8'h00, 1, 8'h55, 8'hAA, "R1 reset selects irr");

    // R3 selection and persistence
    step(1, 8'h0B, 0, 8'h00, 8'h00, "R3 write 0B");
    step(0, 8'h00, 1, 8'h11, 8'h22, "R3 isr read");
    step(0, 8'h00, 1, 8'h33, 8'h44, "R3 isr persists");
    step(1, 8'h08, 0, 8'h00, 8'h00, "R3 rr0 ris0");
    step(0, 8'h00, 1, 8'h01, 8'h02, "R3 rr0 keeps isr");
    step(1, 8'h0A, 0, 8'h00, 8'h00, "R3 write 0A");
    step(0, 8'h00, 1, 8'h5A, 8'hA5, "R3 irr read");
    step(1, 8'h09, 0, 8'h00, 8'h00, "R3 rr0 ris1");
    step(0, 8'h00, 1, 8'h5A, 8'hA5, "R3 rr0 keeps irr");

    // R2 foreign bytes
    step(1, 8'h1B, 0, 8'h00, 8'h00, "R2 bit4 set");
    step(1, 8'h03, 0, 8'h00, 8'h00, "R2 bit3 clear");
    step(1, 8'h67, 1, 8'h0C, 8'hF0, "R2 foreign no poll");
    step(0, 8'h00, 1, 8'h0C, 8'hF0, "R2 still irr");

    // R4 mask mode
    step(1, 8'h68, 0, 8'h00, 8'h00, "R4 set smm");
    step(1, 8'h28, 0, 8'h00, 8'h00, "R4 esmm0 ignored");
    step(1, 8'h48, 0, 8'h00, 8'h00, "R4 clear smm");

    // R9 top bit
    step(1, 8'h8B, 0, 8'h00, 8'h00, "R9 8B");
    step(0, 8'h00, 1, 8'h10, 8'h20, "R9 8B selects isr");
    step(1, 8'hEA, 0, 8'h00, 8'h00, "R9 EA");
    step(0, 8'h00, 1, 8'h10, 8'h20, "R9 EA selects irr");

    // R5/R6 poll
    step(1, 8'h0C, 0, 8'h00, 8'h00, "R5 poll");
    step(1, 8'h08, 0, 8'h00, 8'h00, "R5 no-poll keeps pending");
    step(0, 8'h00, 1, 8'h28, 8'hFF, "R6 poll byte lowest 3");
    step(0, 8'h00, 1, 8'h28, 8'hFF, "R5 poll used once");
    step(1, 8'h0E, 0, 8'h00, 8'h00, "R5 poll irr");
    step(0, 8'h00, 1, 8'h00, 8'hFF, "R6 poll empty");
    step(1, 8'h0C, 0, 8'h00, 8'h00, "R6 poll");
    step(0, 8'h00, 1, 8'h80, 8'h00, "R6 poll irq7");

    // R8 simultaneous
    step(1, 8'h0B, 1, 8'h3C, 8'hC3, "R8 read old sel");
    step(0, 8'h00, 1, 8'h3C, 8'hC3, "R8 new sel after");
    step(1, 8'h0C, 1, 8'h06, 8'h60, "R8 poll survives read");
    step(0, 8'h00, 1, 8'h06, 8'h60, "R8 poll next read");
    step(0, 8'h00, 0, 8'h00, 8'h00, "R7 idle");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      wd = 8'($urandom);
      if ($urandom_range(3) != 0) wd[4:3] = 2'b01;
      step(($urandom_range(2) != 0), wd, ($urandom_range(1) != 0),
           8'($urandom), 8'($urandom), "R3/R5/R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule